// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits between a host write port and the page buffer of a byte-wide non-volatile memory. It watches every host write for fixed address/data command patterns. It keeps a persistent write-protect flag, and for each write it decides one of three outcomes. The write can be passed on to the page buffer, it can be swallowed as a command byte, or it can be turned into a write period that stores nothing. Protection is switched on by a three-write command and off by a six-write command. While protection is on, data reaches the buffer only after the three-write enabling prefix has been issued.

Command bytes must arrive within `LOAD_TMO` clock cycles of each other. The same window holds the page-load period that the enabling prefix opens. The flag changes only when the external programming timer reports the end of a write period (`prog_done`), so a command takes effect even when no data follows it. The flag has its own factory reset. The ordinary power-on reset clears the sequencer but never touches the flag.

Top module: `wp_cmd_seq`

## Requirements
- R1: While `factory_rst` is high, `prot_on` is driven to 0 by the next clock edge. While `rst` is high, `fwd_we` and `timer_only` are 0.
- R2: Asserting `rst` alone leaves `prot_on` unchanged.
- R3: When protection is off and the sequencer is idle, a write that is not the first command byte produces `fwd_we`=1 in the cycle after the strobe, with `fwd_addr`/`fwd_data` equal to the written values.
- R4: The sequence data 0xAA at address 0x5555, 0x55 at 0x2AAA, then 0xA0 at 0x5555 forwards none of its three bytes. It pulses `timer_only` for the last byte. `prot_on` becomes 1 in the cycle after the next `prog_done` pulse, and not before.
- R5: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 forward nothing and pulse `timer_only` on the sixth. `prot_on` becomes 0 in the cycle after the next `prog_done`.
- R6: While `prot_on`=1, a write outside a command sequence or an open page window gives `timer_only`=1 and `fwd_we`=0 in the following cycle.
- R7: Once the three-write enable prefix completes, every further write within the window is forwarded, whether protection is on or off, and protection stays on.
- R8: Command matching compares address bits 14 to 0 only. Higher address bits are ignored.
- R9: A write that breaks a sequence in progress returns the sequencer to idle and is handled as an ordinary write (R3 or R6).
- R10: A gap of at most `LOAD_TMO` clock edges between write strobes keeps a sequence or window alive. A gap of `LOAD_TMO`+1 or more abandons it, and the next write is handled as if the sequencer were idle.
- R11: `fwd_we` and `timer_only` are never high together, and each is high only in the cycle after a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset; clears the sequencer, not the flag |
| factory_rst | input | 1 | Synchronous reset of the protect flag to 0 |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| prog_done | input | 1 | End-of-write-period pulse from the programming timer |
| prot_on | output | 1 | Write-protect flag |
| fwd_we | output | 1 | Registered write enable to the page buffer |
| fwd_addr | output | ADDR_W | Address of the forwarded write |
| fwd_data | output | 8 | Data of the forwarded write |
| timer_only | output | 1 | Start a write period that stores nothing |

## Verification
The assertions assume that `wr_stb` is a single-cycle pulse per host write. They also assume that `prog_done` is never high in the same cycle as a strobe, and that `factory_rst` is applied at start-up before anything relies on the flag. The stimulus meets these assumptions because every write, idle gap and `prog_done` pulse is its own negedge-driven step. The stimulus mixes command bytes, whose upper address bits are randomised, with random data and random gap lengths around the timeout. It also includes occasional power-on resets.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int MATCH_W = 15;
  localparam int BYTE_W  = 8;
  localparam int NUM_CMD = 5;

  localparam int K_AA = 0;
  localparam int K_55 = 1;
  localparam int K_A0 = 2;
  localparam int K_80 = 3;
  localparam int K_20 = 4;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_A1, SQ_A2, SQ_D3, SQ_D4, SQ_D5, SQ_OPEN
  } seq_state_t;

  function automatic logic [MATCH_W-1:0] cmd_addr(input int k);
    return (k == K_55) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [BYTE_W-1:0] cmd_data(input int k);
    case (k)
      K_AA:    return 8'hAA;
      K_55:    return 8'h55;
      K_A0:    return 8'hA0;
      K_80:    return 8'h80;
      default: return 8'h20;
    endcase
  endfunction
endpackage

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
  import wp_pkg::*;
(
  input  logic [MATCH_W-1:0] addr,
  input  logic [BYTE_W-1:0]  data,
  output logic [NUM_CMD-1:0] hit
);
  for (genvar i = 0; i < NUM_CMD; i++) begin : g_pat
    assign hit[i] = (addr == cmd_addr(i)) && (data == cmd_data(i));
  end
endmodule

// File: rtl/wp_load_timer.sv
module wp_load_timer #(
  parameter int LOAD_TMO = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic kick,
  output logic expire
);
  localparam int CNT_W = $clog2(LOAD_TMO);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_TMO - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || kick || !active) cnt_q <= '0;
    else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
  end

  assign expire = active && !kick && (cnt_q == LAST);

  // R10: the window counter restarts on every write
  a_r10_kick_restarts: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt_q == '0));
endmodule

// File: rtl/wp_flag.sv
module wp_flag (
  input  logic clk,
  input  logic rst,
  input  logic factory_rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic prog_done,
  output logic prot
);
  logic pend_vld, pend_val;

  always_ff @(posedge clk) begin
    if (factory_rst) prot <= 1'b0;
    else if (!rst && prog_done && pend_vld) prot <= pend_val;
  end

  always_ff @(posedge clk) begin
    if (factory_rst || rst) begin
      pend_vld <= 1'b0;
      pend_val <= 1'b0;
    end else if (set_req) begin
      pend_vld <= 1'b1;
      pend_val <= 1'b1;
    end else if (clr_req) begin
      pend_vld <= 1'b1;
      pend_val <= 1'b0;
    end else if (prog_done) begin
      pend_vld <= 1'b0;
    end
  end

  // R2: power-on reset never changes the flag
  a_r2_por_keeps_flag: assert property (@(posedge clk) disable iff (factory_rst)
    rst |=> $stable(prot));
  // R4 / R5: the flag only moves at the end of a write period
  a_r4_flag_on_done: assert property (@(posedge clk) disable iff (factory_rst)
    !$stable(prot) |-> $past(prog_done));
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
  import wp_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int LOAD_TMO = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              factory_rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              prot_on,
  output logic              fwd_we,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [BYTE_W-1:0] fwd_data,
  output logic              timer_only
);
  logic [NUM_CMD-1:0] hit;
  seq_state_t st_q, st_d;
  logic expire, set_req, clr_req, fwd_d, tmr_d, plain;

  wp_cmd_match u_match (
    .addr (wr_addr[MATCH_W-1:0]),
    .data (wr_data),
    .hit  (hit)
  );

  wp_load_timer #(.LOAD_TMO(LOAD_TMO)) u_window (
    .clk    (clk),
    .rst    (rst),
    .active (st_q != SQ_IDLE),
    .kick   (wr_stb),
    .expire (expire)
  );

  wp_flag u_flag (
    .clk         (clk),
    .rst         (rst),
    .factory_rst (factory_rst),
    .set_req     (set_req),
    .clr_req     (clr_req),
    .prog_done   (prog_done),
    .prot        (prot_on)
  );

  always_comb begin
    st_d    = st_q;
    set_req = 1'b0;
    clr_req = 1'b0;
    fwd_d   = 1'b0;
    tmr_d   = 1'b0;
    plain   = 1'b0;
    if (wr_stb) begin
      unique case (st_q)
        SQ_IDLE: if (hit[K_AA]) st_d = SQ_A1;
                 else plain = 1'b1;
        SQ_A1:   if (hit[K_55]) st_d = SQ_A2;
                 else begin plain = 1'b1; st_d = SQ_IDLE; end
        SQ_A2:   if (hit[K_A0]) begin
                   st_d = SQ_OPEN; set_req = 1'b1; tmr_d = 1'b1;
                 end else if (hit[K_80]) st_d = SQ_D3;
                 else begin plain = 1'b1; st_d = SQ_IDLE; end
        SQ_D3:   if (hit[K_AA]) st_d = SQ_D4;
                 else begin plain = 1'b1; st_d = SQ_IDLE; end
        SQ_D4:   if (hit[K_55]) st_d = SQ_D5;
                 else begin plain = 1'b1; st_d = SQ_IDLE; end
        SQ_D5:   if (hit[K_20]) begin
                   st_d = SQ_IDLE; clr_req = 1'b1; tmr_d = 1'b1;
                 end else begin plain = 1'b1; st_d = SQ_IDLE; end
        SQ_OPEN: fwd_d = 1'b1;
        default: st_d = SQ_IDLE;
      endcase
      if (plain) begin
        if (prot_on) tmr_d = 1'b1;
        else         fwd_d = 1'b1;
      end
    end else if (expire) begin
      st_d = SQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SQ_IDLE;
      fwd_we     <= 1'b0;
      timer_only <= 1'b0;
      fwd_addr   <= '0;
      fwd_data   <= '0;
    end else begin
      st_q       <= st_d;
      fwd_we     <= fwd_d;
      timer_only <= tmr_d;
      if (fwd_d) begin
        fwd_addr <= wr_addr;
        fwd_data <= wr_data;
      end
    end
  end

  // R11: never both outcomes for one write
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    !(fwd_we && timer_only));
  // R11: outcomes follow a strobe by one cycle
  a_r11_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (fwd_we || timer_only) |-> $past(wr_stb));
  // R6: protected idle write without a command start stores nothing
  a_r6_protected_plain: assert property (@(posedge clk) disable iff (rst || factory_rst)
    (wr_stb && prot_on && st_q == SQ_IDLE && !hit[K_AA]) |=> (timer_only && !fwd_we));
  // R4 / R5: command bytes never reach the page buffer
  a_r4_cmd_start_swallowed: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && st_q == SQ_IDLE && hit[K_AA]) |=> !fwd_we && !timer_only);
endmodule

// File: tb/test_wp_cmd_seq.sv
module test_wp_cmd_seq;
  localparam int AW  = 19;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst, factory_rst, wr_stb, prog_done;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic prot_on, fwd_we, timer_only;
  logic [AW-1:0] fwd_addr;
  logic [7:0] fwd_data;

  always #5 clk = ~clk;

  wp_cmd_seq #(.ADDR_W(AW), .LOAD_TMO(TMO)) i_wp_cmd_seq (
    .clk(clk), .rst(rst), .factory_rst(factory_rst), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
    .prot_on(prot_on), .fwd_we(fwd_we), .fwd_addr(fwd_addr),
    .fwd_data(fwd_data), .timer_only(timer_only)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state: 0 idle,1 A1,2 A2,3 D3,4 D4,5 D5,6 open
  int m_st = 0, m_idle = 0;
  bit m_prot = 0, m_pvld = 0, m_pval = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_cmd(input logic [AW-1:0] a, input logic [7:0] d,
                                input logic [14:0] ca, input logic [7:0] cd);
    return (a[14:0] == ca) && (d == cd);
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [7:0] d,
                             output bit ef, output bit et);
    bit ord = 0;
    ef = 0; et = 0;
    if (m_st != 0 && m_idle + 1 > TMO) m_st = 0;   // R10 window lapse
    case (m_st)
      0: if (is_cmd(a, d, 15'h5555, 8'hAA)) m_st = 1; else ord = 1;
      1: if (is_cmd(a, d, 15'h2AAA, 8'h55)) m_st = 2; else begin ord = 1; m_st = 0; end
      2: if (is_cmd(a, d, 15'h5555, 8'hA0)) begin m_st = 6; m_pvld = 1; m_pval = 1; et = 1; end
         else if (is_cmd(a, d, 15'h5555, 8'h80)) m_st = 3;
         else begin ord = 1; m_st = 0; end
      3: if (is_cmd(a, d, 15'h5555, 8'hAA)) m_st = 4; else begin ord = 1; m_st = 0; end
      4: if (is_cmd(a, d, 15'h2AAA, 8'h55)) m_st = 5; else begin ord = 1; m_st = 0; end
      5: if (is_cmd(a, d, 15'h5555, 8'h20)) begin m_st = 0; m_pvld = 1; m_pval = 0; et = 1; end
         else begin ord = 1; m_st = 0; end
      default: ef = 1;
    endcase
    if (ord) begin
      if (m_prot) et = 1; else ef = 1;
    end
    m_idle = 0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input string req);
    bit ef, et;
    model_write(a, d, ef, et);
    wr_stb = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 0;
    check(fwd_we == ef, req, fwd_we, ef);
    check(timer_only == et, req, timer_only, et);
    if (ef) check(fwd_addr == a && fwd_data == d, {req, " R3 payload"},
                  {fwd_addr, fwd_data}, {a, d});
    check(!(fwd_we && timer_only), "R11", {fwd_we, timer_only}, 0);
    check(prot_on == m_prot, {req, " flag"}, prot_on, m_prot);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_idle++;
    end
  endtask

  task automatic done_pulse(input string req);
    prog_done = 1;
    @(negedge clk);
    prog_done = 0;
    if (m_pvld) m_prot = m_pval;
    m_pvld = 0;
    m_idle++;
    check(prot_on == m_prot, req, prot_on, m_prot);
  endtask

  task automatic por(input string req);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_st = 0; m_pvld = 0; m_idle = 0;
    check(prot_on == m_prot, req, prot_on, m_prot);
    check(!fwd_we && !timer_only, "R1 outputs idle", {fwd_we, timer_only}, 0);
  endtask

  task automatic enable_seq(input logic [3:0] hi, input string req);
    wr({hi, 15'h5555}, 8'hAA, req);
    wr({hi, 15'h2AAA}, 8'h55, req);
    wr({hi, 15'h5555}, 8'hA0, req);
  endtask

  task automatic disable_seq(input string req);
    wr(19'h05555, 8'hAA, req);
    wr(19'h02AAA, 8'h55, req);
    wr(19'h05555, 8'h80, req);
    wr(19'h05555, 8'hAA, req);
    wr(19'h02AAA, 8'h55, req);
    wr(19'h05555, 8'h20, req);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst = 1; factory_rst = 1; wr_stb = 0; prog_done = 0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    factory_rst = 0; rst = 0;
    check(prot_on == 1'b0, "R1 flag after factory reset", prot_on, 0);
    check(!fwd_we && !timer_only, "R1 outputs", {fwd_we, timer_only}, 0);

    // R3 plain writes while unprotected
    wr(19'h12345, 8'h3C, "R3");
    wr(19'h7FFFF, 8'hAA, "R3");

    // R4 enable, flag waits for end of period
    enable_seq(4'h0, "R4");
    idle(TMO + 2);
    check(prot_on == 1'b0, "R4 flag before done", prot_on, 0);
    done_pulse("R4 flag after done");

    // R6 protected plain write
    wr(19'h00100, 8'h11, "R6");

    // R2 power-on reset keeps flag
    por("R2");

    // R7 + R8 prefix with high address bits set, then data
    enable_seq(4'hB, "R8");
    wr(19'h40010, 8'h01, "R7");
    wr(19'h40011, 8'h02, "R7");
    wr(19'h40012, 8'h03, "R7");
    idle(TMO + 1);
    done_pulse("R7 stays protected");

    // R9 mismatch while protected
    wr(19'h05555, 8'hAA, "R9");
    wr(19'h02AAA, 8'h12, "R9 broken");
    idle(TMO + 1);

    // R10 gap exactly TMO accepted, TMO+1 rejected
    wr(19'h05555, 8'hAA, "R10");
    idle(TMO - 1);
    wr(19'h02AAA, 8'h55, "R10 edge ok");
    idle(TMO);
    wr(19'h05555, 8'hA0, "R10 lapsed");
    idle(TMO + 1);

    // R5 disable
    disable_seq("R5");
    idle(TMO + 1);
    check(prot_on == 1'b1, "R5 flag before done", prot_on, 1);
    done_pulse("R5 flag after done");
    wr(19'h00222, 8'h5A, "R5 R3 writes resume");

    // R9 mismatch while unprotected forwards the breaking write
    wr(19'h05555, 8'hAA, "R9");
    wr(19'h05555, 8'h77, "R9 forward");

    // random phase
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = $urandom % 100;
      if (r < 8) done_pulse("R4 R5 random done");
      else if (r < 18) idle($urandom % (TMO + 3));
      else if (r < 19) por("R2 random");
      else if (r < 60) begin
        int k;
        logic [14:0] ca;
        logic [7:0] cd;
        k = $urandom % 5;
        ca = (k == 1 || k == 4) ? 15'h2AAA : 15'h5555;
        case (k)
          0, 3: cd = 8'hAA;
          1, 4: cd = 8'h55;
          2: cd = ($urandom % 2) ? 8'hA0 : 8'h20;
          default: cd = 8'h80;
        endcase
        wr({4'($urandom), ca}, cd, "R8 R9 random command");
      end else begin
        wr(19'($urandom), 8'($urandom), "R3 R6 R7 random");
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule